// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

The bridge connects one 32-bit host-visible access word to a bank of 256 internal byte-wide registers. The registers sit behind a slow access path. The host places an internal address, a data byte and a direction bit in one write. The bridge then sets a busy flag and runs the internal access. When the access ends it clears busy. For a read, the fetched byte is returned in the top byte of the same word. Software is expected to poll the busy flag until it drops, so every access finishes within a fixed, small number of cycles set by a parameter.

The bank holds plain storage for all 256 addresses. This includes the ranges that a protocol engine would use as a transmit buffer (0x10 to 0x1F) and a receive buffer (0x20 to 0x2F). The host-side retry limit and mutual exclusion between software threads are left to the caller.

Top module: `idx_byte_bridge`

## Requirements
- R1: After reset the access word reads all zeros: busy is low, the read-data byte is 0x00 and the echoed command is zero. Every internal byte reads back as 0x00.
- R2: The access word has this layout. Bits 7:0 hold the address of the last accepted command, bits 15:8 its data byte and bit 16 its direction (1 = write). Bit 23 is busy and bits 31:24 are the read-data byte. Bits 22:17 read as zero.
- R3: An accepted command with bit 16 set stores bits 15:8 into the internal byte at address bits 7:0 by the time busy clears.
- R4: An accepted command with bit 16 clear fetches the addressed byte. The byte appears in bits 31:24 in the same cycle that busy reads low again.
- R5: The first clock edge with `host_we` high and busy low accepts a command. Busy reads high from the next cycle and stays high for exactly LATENCY cycles.
- R6: A command presented while busy is high is dropped. The pending access completes with its original address, data and direction, and the echoed command fields do not change.
- R7: The read-data byte holds its value until the next read completes. Completed writes leave it unchanged.
- R8: No internal access starts unless `host_we` is asserted. Driving command bits with `host_we` low leaves busy low and the access word unchanged.
- R9: All 256 addresses are independent storage, including the end addresses 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the host side and the internal bank |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the access word |
| host_wcmd | input | 17 | Writable fields of the access word: address 7:0, data 15:8, direction 16 |
| host_rdata | output | 32 | Access word as seen by the host: echoed command, busy and read-data byte |

## Verification
The hardest case to reach is a second command that lands while the first access is still in flight. The bench handles it by issuing a write and, one cycle after busy rises, presenting a conflicting write and then a read to other addresses. It then confirms three things: the echoed fields did not change, the original byte was stored, and the intruding address still reads zero. A read is checked on the exact cycle busy falls. A write that follows it is checked to leave the top byte untouched.

// File: rtl/idx_byte_bridge.sv
module idx_byte_bridge #(
  parameter int LATENCY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [16:0] host_wcmd,
  output logic [31:0] host_rdata
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam int DEPTH = 256;

  logic [7:0]    bank [DEPTH];
  logic [7:0]    cmd_addr, cmd_data, rd_q;
  logic          cmd_we, busy;
  logic [CW-1:0] cnt;

  wire accept = host_we & ~busy;
  wire done   = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_we   <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      rd_q     <= '0;
    end else if (accept) begin
      cmd_addr <= host_wcmd[7:0];
      cmd_data <= host_wcmd[15:8];
      cmd_we   <= host_wcmd[16];
      busy     <= 1'b1;
      cnt      <= CW'(LATENCY - 1);
    end else if (done) begin
      busy <= 1'b0;
      if (!cmd_we) rd_q <= bank[cmd_addr];
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (done && cmd_we) begin
      bank[cmd_addr] <= cmd_data;
    end
  end

  assign host_rdata = {rd_q, busy, 6'b0, cmd_we, cmd_data, cmd_addr};
endmodule

// File: rtl/idx_byte_bridge_chk.sv
module idx_byte_bridge_chk #(
  parameter int LATENCY = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [31:0] host_rdata
);
  wire busy = host_rdata[23];
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !busy) |=> busy);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == LATENCY));

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(host_rdata[16:0]));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || host_rdata[16]) |=> $stable(host_rdata[31:24]));

  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !host_we) |=> !busy);

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[22:17] == 6'd0);
endmodule

bind idx_byte_bridge idx_byte_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rdata(host_rdata)
);

// File: tb/test_idx_byte_bridge.sv
`timescale 1ns/1ps
module test_idx_byte_bridge;
  localparam int LAT = 4;
  localparam int NV = 13;
  // {we, addr, data, expected read byte after completion}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h10, 8'hA5, 8'h00},
    {1'b1, 8'h1F, 8'h5A, 8'h00},
    {1'b1, 8'h20, 8'hC3, 8'h00},
    {1'b1, 8'hFF, 8'h81, 8'h00},
    {1'b0, 8'h10, 8'h00, 8'hA5},
    {1'b1, 8'h00, 8'h7E, 8'hA5},
    {1'b0, 8'h1F, 8'h00, 8'h5A},
    {1'b0, 8'h20, 8'h00, 8'hC3},
    {1'b0, 8'hFF, 8'h00, 8'h81},
    {1'b0, 8'h00, 8'h00, 8'h7E},
    {1'b0, 8'h2F, 8'h00, 8'h00},
    {1'b1, 8'h2F, 8'h3C, 8'h00},
    {1'b0, 8'h2F, 8'h00, 8'h3C}
  };

  logic clk = 0, rst_n = 0, host_we = 0;
  logic [16:0] host_wcmd = '0;
  logic [31:0] host_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  idx_byte_bridge #(.LATENCY(LAT)) i_idx_byte_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we),
    .host_wcmd(host_wcmd), .host_rdata(host_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1;
    host_wcmd = {we, d, a};
    @(negedge clk);
    host_we = 1'b0;
    host_wcmd = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (host_rdata[23] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] exp_rd, input string req);
    int n;
    issue(we, a, d);
    check("R5 busy high after accept", {31'd0, host_rdata[23]}, 32'd1);
    wait_idle(n);
    check("R5 busy length", n, LAT);
    check(req, host_rdata, {exp_rd, 1'b0, 6'd0, we, d, a});
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset word", host_rdata, 32'd0);

    // R8: command bits without strobe start nothing
    host_wcmd = {1'b1, 8'hEE, 8'h44};
    repeat (5) begin
      @(negedge clk);
      check("R8 no access without strobe", host_rdata, 32'd0);
    end
    host_wcmd = '0;

    // R1: untouched byte reads zero
    access(1'b0, 8'h44, 8'h00, 8'h00, "R1 bank reset to zero");

    // Table walk: R2 R3 R4 R7 R9
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
             VEC[i][24] ? "R3 R7 R2 write completes" : "R4 R9 R2 read result");
    end

    // R6: commands during busy are dropped
    issue(1'b1, 8'h30, 8'h11);
    host_we = 1'b1;
    host_wcmd = {1'b1, 8'h99, 8'h31};
    @(negedge clk);
    host_wcmd = {1'b0, 8'h00, 8'h40};
    @(negedge clk);
    host_we = 1'b0;
    host_wcmd = '0;
    check("R6 echo unchanged while busy", host_rdata, {8'h3C, 1'b1, 6'd0, 1'b1, 8'h11, 8'h30});
    wait_idle(n);
    check("R6 pending completes", host_rdata, {8'h3C, 1'b0, 6'd0, 1'b1, 8'h11, 8'h30});
    access(1'b0, 8'h30, 8'h00, 8'h11, "R6 original write stored");
    access(1'b0, 8'h31, 8'h00, 8'h00, "R6 dropped write not stored");

    // R1: reset clears the bank and the word
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after re-reset", host_rdata, 32'd0);
    access(1'b0, 8'h10, 8'h00, 8'h00, "R1 bank cleared by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule